// File: doc/BRIEF.md
# SDRAM Controller with Refresh Scheduler

This block sits between a simple single-port request interface and one 16-bit, four-bank synchronous DRAM. A user presents a word address split into bank, row and column fields, a read/write flag, write data and a two-bit byte-enable mask. The controller turns each request into an ACTIVE command, a column command with auto-precharge, and a fixed wait while the row closes. This is a closed-page policy: each access opens its row and leaves it closed behind it. Requests are served one at a time, in order.

After reset the controller runs the power-up sequence. It issues NOPs for the settling time, then a precharge of all banks, two auto-refreshes and a mode-register write that selects burst length 1, sequential order and the configured CAS latency. An interval counter raises a refresh request at the average refresh spacing. A pending refresh wins over a new user request at the next idle point. Every timing limit is given in nanoseconds and rounded up to whole clock cycles when the design is elaborated.

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is asserted, CKE is low, the command pins show NOP (CS, RAS, CAS, WE = 0,1,1,1), req_ready and rd_valid are low and DQ is not driven. CKE is high from the first cycle after reset, and every command other than NOP follows a cycle with CKE high.
- R2: After reset the command pins show only NOP for INIT_CYC = ceil(T_INIT_NS/CLK_NS) cycles. The next command is PRECHARGE (0,0,1,0) with address bit 10 high, which closes all banks.
- R3: The PRECHARGE is followed by two AUTO REFRESH commands (0,0,0,1), the first at least tRP cycles after the precharge and the second at least tRC cycles after the first. A MODE SET (0,0,0,0) follows at least tRC cycles after the second refresh, with bank 0 and an address of CAS_LAT in bits 6:4 and zeros elsewhere. No command follows the MODE SET for tMRD cycles, and req_ready stays low until this whole sequence is done.
- R4: ACTIVE (0,0,1,1) carries the bank from req_addr[22:21] on sd_ba and the row from req_addr[20:9] on sd_addr.
- R5: The column command, READ (0,1,0,1) or WRITE (0,1,0,0), comes at least tRCD cycles after ACTIVE. It uses the same bank, puts req_addr[8:0] on sd_addr[8:0] and sets sd_addr[10] high to request auto-precharge.
- R6: DQ is driven only in the WRITE cycle, and it then carries the request's write data. In that cycle sd_dqm[b] = ~be[b], where byte 0 is bits 7:0. A write with be = 00 leaves the memory word unchanged.
- R7: If READ is on the pins in cycle c, then rd_valid pulses high for one cycle in cycle c+CAS_LAT+1. rd_data holds the value on sd_dq_in during cycle c+CAS_LAT. Reads return in request order, one pulse per read.
- R8: An ACTIVE comes at least GAP = max(tRC, tRAS+tRP, tRCD+CAS_LAT+1+tRP) cycles after the previous ACTIVE, and at least tRC cycles after any AUTO REFRESH. Every ns limit is rounded up: cycles = ceil(ns/CLK_NS).
- R9: A refresh becomes pending every REFI_CYC cycles and is issued before any new request at the next idle point. Consecutive refreshes during operation are at most REFI_CYC+GAP cycles apart. A refresh is issued only with all banks closed, at least GAP cycles after the last ACTIVE.
- R10: A request is accepted on a cycle in which req_valid and req_ready are both high. Its ACTIVE is on the pins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | {bank[1:0], row[11:0], column[8:0]} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for the write |
| req_ready | output | 1 | Controller can take a request this cycle |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed row / column / mode address |
| sd_dqm | output | 2 | Byte data mask |
| sd_dq_out | output | 16 | Write data toward the memory |
| sd_dq_oe | output | 1 | Drive enable for the DQ pads |
| sd_dq_in | input | 16 | Data returned by the memory |

## Verification
Assertions watch the command pins on every cycle:
- CKE is high in the cycle before each command.
- Column commands keep the activate-to-column gap and carry the auto-precharge bit.
- Activates and refreshes keep their spacing from each other.
- DQ is driven only under a WRITE.
- An accepted request is followed at once by ACTIVE.

Only the bench scenarios can show the rest. These are the length and order of the power-up sequence, the mode word, and the mapping of address fields onto bank, row and column pins. They also cover byte-masked writes and read-back values with their exact return cycle, and the refresh interval held while traffic is continuous and while the controller is idle.

// File: rtl/sdram_ctrl.sv
`timescale 1ns/1ps
module sdram_ctrl #(
  parameter int CLK_NS    = 5,
  parameter int T_RCD_NS  = 15,
  parameter int T_RP_NS   = 15,
  parameter int T_RAS_NS  = 42,
  parameter int T_RC_NS   = 57,
  parameter int T_REFI_NS = 15600,
  parameter int T_INIT_NS = 200000,
  parameter int MRD_CYC   = 2,
  parameter int CAS_LAT   = 3,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic                              req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]                 req_wdata,
  input  logic [DATA_W/8-1:0]               req_be,
  output logic                              req_ready,
  output logic                              rd_valid,
  output logic [DATA_W-1:0]                 rd_data,
  output logic                              sd_cke,
  output logic                              sd_cs_n,
  output logic                              sd_ras_n,
  output logic                              sd_cas_n,
  output logic                              sd_we_n,
  output logic [BANK_W-1:0]                 sd_ba,
  output logic [ROW_W-1:0]                  sd_addr,
  output logic [DATA_W/8-1:0]               sd_dqm,
  output logic [DATA_W-1:0]                 sd_dq_out,
  output logic                              sd_dq_oe,
  input  logic [DATA_W-1:0]                 sd_dq_in
);
  localparam int ADDR_W   = BANK_W + ROW_W + COL_W;
  localparam int BE_W     = DATA_W / 8;
  localparam int RCD_CYC  = (T_RCD_NS  + CLK_NS - 1) / CLK_NS;
  localparam int RP_CYC   = (T_RP_NS   + CLK_NS - 1) / CLK_NS;
  localparam int RAS_CYC  = (T_RAS_NS  + CLK_NS - 1) / CLK_NS;
  localparam int RC_CYC   = (T_RC_NS   + CLK_NS - 1) / CLK_NS;
  localparam int REFI_CYC = (T_REFI_NS + CLK_NS - 1) / CLK_NS;
  localparam int INIT_CYC = (T_INIT_NS + CLK_NS - 1) / CLK_NS;
  localparam int GAP_A    = (RC_CYC > RAS_CYC + RP_CYC) ? RC_CYC : RAS_CYC + RP_CYC;
  localparam int RDC_CYC  = RCD_CYC + CAS_LAT + 1 + RP_CYC;
  localparam int GAP_CYC  = (GAP_A > RDC_CYC) ? GAP_A : RDC_CYC;
  localparam int TMR_W    = $clog2(INIT_CYC + 1);
  localparam int REF_W    = $clog2(REFI_CYC + 1);
  localparam int CW       = $clog2(GAP_CYC + 1);
  localparam logic [ROW_W-1:0] A10      = ROW_W'(1) << 10;
  localparam logic [ROW_W-1:0] MODE_VAL = ROW_W'(CAS_LAT << 4);

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD  = 4'b0101,
                         C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;

  typedef enum logic [2:0] {S_PWR, S_IREF, S_MODE, S_IDLE, S_COL} st_t;

  st_t               st;
  logic [TMR_W-1:0]  tmr;
  logic [REF_W-1:0]  refi;
  logic              ref_pend, iref_two;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] a_q;
  logic              wr_q;
  logic [DATA_W-1:0] wd_q;
  logic [BE_W-1:0]   be_q;
  logic [CAS_LAT:0]  rd_sh;

  wire tz     = (tmr == '0);
  wire col_go = (st == S_COL) && tz;

  assign req_ready = (st == S_IDLE) && tz && !ref_pend;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_PWR;
      tmr       <= TMR_W'(INIT_CYC);
      refi      <= REF_W'(REFI_CYC - 1);
      ref_pend  <= 1'b0;
      iref_two  <= 1'b0;
      cmd_q     <= C_NOP;
      sd_cke    <= 1'b0;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dqm    <= '0;
      sd_dq_oe  <= 1'b0;
      sd_dq_out <= '0;
      a_q       <= '0;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      be_q      <= '0;
      rd_sh     <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      sd_cke   <= 1'b1;
      cmd_q    <= C_NOP;
      sd_dq_oe <= 1'b0;
      sd_dqm   <= '0;
      rd_sh    <= {rd_sh[CAS_LAT-1:0], col_go && !wr_q};
      rd_valid <= rd_sh[CAS_LAT];
      if (rd_sh[CAS_LAT]) rd_data <= sd_dq_in;

      if (!tz) tmr <= tmr - 1'b1;
      else begin
        case (st)
          S_PWR: begin
            cmd_q   <= C_PRE;
            sd_addr <= A10;
            tmr     <= TMR_W'(RP_CYC - 1);
            st      <= S_IREF;
          end
          S_IREF: begin
            cmd_q    <= C_REF;
            tmr      <= TMR_W'(RC_CYC - 1);
            iref_two <= 1'b1;
            if (iref_two) st <= S_MODE;
          end
          S_MODE: begin
            cmd_q   <= C_MRS;
            sd_ba   <= '0;
            sd_addr <= MODE_VAL;
            tmr     <= TMR_W'(MRD_CYC - 1);
            st      <= S_IDLE;
          end
          S_IDLE: begin
            if (ref_pend) begin
              cmd_q    <= C_REF;
              ref_pend <= 1'b0;
              tmr      <= TMR_W'(RC_CYC - 1);
            end else if (req_valid) begin
              a_q     <= req_addr;
              wr_q    <= req_write;
              wd_q    <= req_wdata;
              be_q    <= req_be;
              cmd_q   <= C_ACT;
              sd_ba   <= req_addr[ADDR_W-1 -: BANK_W];
              sd_addr <= req_addr[COL_W +: ROW_W];
              tmr     <= TMR_W'(RCD_CYC - 1);
              st      <= S_COL;
            end
          end
          S_COL: begin
            cmd_q   <= wr_q ? C_WR : C_RD;
            sd_ba   <= a_q[ADDR_W-1 -: BANK_W];
            sd_addr <= ROW_W'(a_q[COL_W-1:0]) | A10;
            if (wr_q) begin
              sd_dq_oe  <= 1'b1;
              sd_dq_out <= wd_q;
              sd_dqm    <= ~be_q;
            end
            tmr <= TMR_W'(GAP_CYC - RCD_CYC - 1);
            st  <= S_IDLE;
          end
          default: st <= S_PWR;
        endcase
      end

      if (refi == '0) begin
        refi     <= REF_W'(REFI_CYC - 1);
        ref_pend <= 1'b1;
      end else refi <= refi - 1'b1;
    end
  end

  logic [CW-1:0] since_act, since_ref;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= CW'(GAP_CYC);
      since_ref <= CW'(GAP_CYC);
    end else begin
      since_act <= (cmd_q == C_ACT) ? CW'(1) :
                   (since_act == CW'(GAP_CYC)) ? since_act : since_act + 1'b1;
      since_ref <= (cmd_q == C_REF) ? CW'(1) :
                   (since_ref == CW'(GAP_CYC)) ? since_ref : since_ref + 1'b1;
    end
  end

  assert_cke_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != C_NOP) |-> $past(sd_cke));
  assert_act_to_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_RD || cmd_q == C_WR) |-> (since_act >= CW'(RCD_CYC) && sd_addr[10]));
  assert_dq_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd_q == C_WR));
  assert_act_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_ACT) |-> (since_act >= CW'(GAP_CYC) && since_ref >= CW'(RC_CYC)));
  assert_ref_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_REF) |-> (since_act >= CW'(GAP_CYC) && since_ref >= CW'(RC_CYC)));
  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_q == C_ACT));
endmodule

// File: tb/sdram_ctrl_tb.sv
`timescale 1ns/1ps
module sdram_ctrl_tb;
  localparam int CL = 3;
  localparam int WD_LIMIT = 150000;
  localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD = 4'b0101,
                         K_WR = 4'b0100, K_PRE = 4'b0010, K_REF = 4'b0001,
                         K_MRS = 4'b0000;

  function automatic int cyc(input int ns);
    return (ns + 4) / 5;
  endfunction
  localparam int RCD = (15 + 4) / 5, RP = (15 + 4) / 5, RAS = (42 + 4) / 5, RC = (57 + 4) / 5;
  localparam int REFI = (15600 + 4) / 5, INIT = (200000 + 4) / 5, MRD = 2;
  localparam int G1 = (RC > RAS + RP) ? RC : RAS + RP;
  localparam int GAP = (G1 > RCD + CL + 1 + RP) ? G1 : RCD + CL + 1 + RP;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [15:0] rd_data, sd_dq_out;
  logic [15:0] sd_dq_in = 16'hDEAD;
  logic [1:0] sd_ba, sd_dqm;
  logic [11:0] sd_addr;

  always #2.5 clk = ~clk;

  sdram_ctrl #(.CAS_LAT(CL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask
  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask
  function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] d, input logic [1:0] be);
    return {be[1] ? d[15:8] : o[15:8], be[0] ? d[7:0] : o[7:0]};
  endfunction

  logic [22:0] atab [16];
  logic [15:0] refm [16];
  logic [22:0] q_addr[$];
  bit          q_wr[$];
  logic [15:0] q_wd[$];
  logic [1:0]  q_be[$];
  logic [15:0] q_exp[$];
  int          e_n[$];
  logic [15:0] e_d[$];

  logic [15:0] mem [int];
  logic [15:0] rp_d [CL+1];
  bit          rp_v [CL+1];
  bit          bopen [4];
  int n = 0, n_rel = 0, step = 0, last_pre = 0, last_mrs = -1000, last_act = -1000;
  int last_ref = -1000, ref_cnt = 0;
  bit prev_rst = 0, prev_cke = 0, have_ref = 0, early_ready = 0;
  logic [3:0] cmd;

  always @(negedge clk) begin
    n++;
    if (n > WD_LIMIT) begin
      chk(0, "watchdog expired", n, WD_LIMIT);
      finish_run();
    end
    for (int k = CL; k > 0; k--) begin rp_v[k] = rp_v[k-1]; rp_d[k] = rp_d[k-1]; end
    rp_v[0] = 0;
    cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rst_n) begin
      if (!prev_rst) begin
        prev_rst = 1; n_rel = n;
        chk(sd_cke == 1'b1, "R1 cke high after reset", sd_cke, 1);
      end
      if (rd_valid) begin
        chk(e_n.size() != 0, "R7 unexpected rd_valid", 0, 1);
        if (e_n.size() != 0) begin
          chk(n == e_n[0] + CL + 1, "R7 read return cycle", n, e_n[0] + CL + 1);
          chk(rd_data == e_d[0], "R7 read data", rd_data, e_d[0]);
          void'(e_n.pop_front()); void'(e_d.pop_front());
        end
      end
      if (req_ready && step < 4) early_ready = 1;
      if (sd_dq_oe != (cmd == K_WR)) chk(0, "R6 DQ driven outside write", sd_dq_oe, cmd == K_WR);
      if (cmd != K_NOP) chk(prev_cke, "R1 cke before command", prev_cke, 1);
      case (cmd)
        K_NOP: ;
        K_PRE: begin
          chk(step == 0, "R2 precharge only at power-up", step, 0);
          chk(sd_addr[10], "R2 precharge all banks", sd_addr, 12'h400);
          chk(n - n_rel >= INIT && n - n_rel <= INIT + 1, "R2 power-up NOP count", n - n_rel, INIT);
          step = 1; last_pre = n;
          for (int b = 0; b < 4; b++) bopen[b] = 0;
        end
        K_REF: begin
          if (step == 1) begin
            chk(n - last_pre >= RP, "R3 precharge to refresh", n - last_pre, RP); step = 2;
          end else if (step == 2) begin
            chk(n - last_ref >= RC, "R3 refresh spacing", n - last_ref, RC); step = 3;
          end else begin
            chk(step == 4, "R3 refresh order", step, 4);
            chk(!(bopen[0] | bopen[1] | bopen[2] | bopen[3]), "R9 banks closed at refresh", 1, 0);
            chk(n - last_act >= GAP, "R9 activate to refresh", n - last_act, GAP);
            if (have_ref) chk(n - last_ref <= REFI + GAP, "R9 refresh interval", n - last_ref, REFI + GAP);
            have_ref = 1; ref_cnt++;
          end
          last_ref = n;
        end
        K_MRS: begin
          chk(step == 3, "R3 mode set order", step, 3);
          chk(sd_addr == 12'(CL << 4) && sd_ba == 2'd0, "R3 mode word", sd_addr, CL << 4);
          chk(n - last_ref >= RC, "R3 refresh to mode set", n - last_ref, RC);
          step = 4; last_mrs = n;
        end
        K_ACT: begin
          chk(step == 4, "R3 activate before init done", step, 4);
          chk(n - last_mrs >= MRD, "R3 mode delay", n - last_mrs, MRD);
          chk(n - last_act >= GAP, "R8 activate spacing", n - last_act, GAP);
          chk(n - last_ref >= RC, "R8 refresh to activate", n - last_ref, RC);
          chk(!bopen[sd_ba], "R8 bank already open", 1, 0);
          if (q_addr.size() != 0)
            chk({sd_ba, sd_addr} == q_addr[0][22:9], "R4 bank/row mapping", {sd_ba, sd_addr}, q_addr[0][22:9]);
          else chk(0, "R10 activate without request", 0, 1);
          bopen[sd_ba] = 1; last_act = n;
        end
        K_RD, K_WR: begin
          chk(bopen[sd_ba], "R5 column to closed bank", 0, 1);
          chk(sd_addr[10], "R5 auto-precharge bit", sd_addr, 12'h400);
          chk(n - last_act >= RCD, "R5 activate to column", n - last_act, RCD);
          bopen[sd_ba] = 0;
          if (q_addr.size() != 0) begin
            chk({sd_ba, sd_addr[8:0]} == {q_addr[0][22:21], q_addr[0][8:0]}, "R5 bank/column",
                {sd_ba, sd_addr[8:0]}, {q_addr[0][22:21], q_addr[0][8:0]});
            chk((cmd == K_WR) == q_wr[0], "R5 command type", cmd, q_wr[0]);
            if (cmd == K_WR) begin
              chk(sd_dq_oe && sd_dq_out == q_wd[0], "R6 write data", sd_dq_out, q_wd[0]);
              chk(sd_dqm == ~q_be[0], "R6 write mask", sd_dqm, ~q_be[0]);
              mem[int'({sd_ba, q_addr[0][20:0]})] =
                merge(mem.exists(int'({sd_ba, q_addr[0][20:0]})) ? mem[int'({sd_ba, q_addr[0][20:0]})] : 16'h0,
                      sd_dq_out, ~sd_dqm);
            end else begin
              e_n.push_back(n); e_d.push_back(q_exp[0]);
              rp_v[0] = 1;
              rp_d[0] = mem.exists(int'({sd_ba, q_addr[0][20:0]})) ? mem[int'({sd_ba, q_addr[0][20:0]})] : 16'h0;
            end
            void'(q_addr.pop_front()); void'(q_wr.pop_front()); void'(q_wd.pop_front());
            void'(q_be.pop_front()); void'(q_exp.pop_front());
          end else chk(0, "R5 column without request", 0, 1);
        end
        default: chk(0, "R1 unknown command", cmd, K_NOP);
      endcase
    end
    prev_cke = sd_cke;
    sd_dq_in = rp_v[CL] ? rp_d[CL] : 16'hDEAD;
  end

  task automatic issue(input bit wr, input int idx, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    #1;
    req_valid = 1; req_write = wr; req_addr = atab[idx]; req_wdata = d; req_be = be;
    while (!req_ready) begin @(negedge clk); #1; end
    if (wr) refm[idx] = merge(refm[idx], d, be);
    q_addr.push_back(atab[idx]); q_wr.push_back(wr); q_wd.push_back(d);
    q_be.push_back(be); q_exp.push_back(refm[idx]);
    @(negedge clk);
    #1;
    req_valid = 0;
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == K_ACT, "R10 activate follows accept",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, K_ACT);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) begin
      atab[i] = {2'(i % 4), 12'((i * 613 + i * i * 37) % 4096), 9'((i * 31) % 512)};
      refm[i] = 16'h0;
    end
    atab[15] = '1;
    chk(cyc(57) == RC && cyc(42) == 9, "R8 ns rounding", RC, 12);
    repeat (4) @(negedge clk);
    #1;
    chk(sd_cke == 0 && !req_ready && !rd_valid && !sd_dq_oe, "R1 reset outputs",
        {sd_cke, req_ready, rd_valid, sd_dq_oe}, 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == K_NOP, "R1 reset command",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, K_NOP);
    rst_n = 1;
    while (step < 4) @(negedge clk);
    for (int i = 0; i < 16; i++) issue(1, i, 16'(i * 16'h1111 + 16'h0F0F), 2'b11);
    for (int i = 0; i < 16; i++) issue(0, i, 16'h0, 2'b00);
    issue(1, 15, 16'hA5C3, 2'b01);
    issue(1, 15, 16'h7E19, 2'b10);
    issue(1, 15, 16'hFFFF, 2'b00);
    issue(0, 15, 16'h0, 2'b00);
    issue(1, 0, 16'h1234, 2'b00);
    issue(0, 0, 16'h0, 2'b00);
    for (int i = 0; i < 520; i++)
      issue(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)), 16'($urandom), 2'($urandom_range(0, 3)));
    repeat (7000) @(negedge clk);
    for (int i = 0; i < 16; i++) issue(0, i, 16'h0, 2'b00);
    while (q_addr.size() != 0 || e_n.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(!early_ready, "R3 ready low during init", early_ready, 0);
    chk(ref_cnt >= 3, "R9 refreshes issued", ref_cnt, 3);
    finish_run();
  end
endmodule